// File: doc/BRIEF.md
# Random Bit Harvester Register Front End

This block sits between a simple register bus and an analog noise source that delivers one raw entropy bit. Software first switches on the analog side with an activation bit. A settling counter then runs for a fixed number of cycles. When it expires, a ready flag rises, and only after that can the digital enable be set. While the block is enabled, a prescaler samples the entropy bit at a rate set by a clock-range code, and eight samples are assembled into one byte.

A finished byte is placed in a one-entry holding register and raises a valid flag. It is handed out exactly once. Reading the data word clears the flag, and reading the data word while no byte is held returns zero. A byte that completes while the previous one is still unread is dropped, so a held byte is never replaced. An interrupt request follows the valid flag whenever the interrupt enable is set.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x0) reads 0x00000000, the data word (0x4) reads 0, offset 0x8 reads 0, the activation word (0xC) reads 0x00000002 and irq_o is 0.
- R2: Bits [6:0] of the activation word always read 0x02, whatever is written. Bit 7 reads back the last value written to it. Bits [31:8] read 0.
- R3: Write the activation bit (0xC bit 7) as 1 at clock edge A. The ready flag (0x0 bit 7) then reads 0 until edge A+SETTLE_CYC-1 and reads 1 from edge A+SETTLE_CYC.
- R4: A write of 1 to the enable bit (0x0 bit 0) takes effect only if the activation bit and the ready flag are both 1. Otherwise the bit stays 0.
- R5: Writing 0 to the activation bit clears the ready flag and the enable bit from the next read on. A later activation starts the full SETTLE_CYC delay again.
- R6: The clock-range code (0x0 bits [5:2]) is written only while the enable bit is 0. A write while the block is enabled leaves the code unchanged.
- R7: While enabled, one entropy bit is sampled every P cycles. P = ceil(F/5), where F in MHz is the upper bound of the range for the code: 100, 80, 60, 50, 40, 30, 25, 20, 15, 12, 9, 7, 6, 5 for codes 0 to 13, and 100 for codes 14 and 15. The first sample is taken P edges after the enabling write. The first sample becomes data bit 7. After eight samples the valid flag (0x0 bit 1) rises.
- R8: A read of 0x4 while valid returns the byte in bits [7:0] with zeros above it, and clears the valid flag. A read while not valid returns 0.
- R9: A byte that completes while the valid flag is set is discarded, and the held byte is kept unchanged.
- R10: irq_o is 1 exactly when the valid flag and the interrupt enable (0x0 bit 6) are both 1.
- R11: Offset 0x8 ignores writes and reads 0. Bits [31:8] of the control word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; read side effects take place at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_i |
| entropy_i | input | 1 | Raw bit from the noise source |
| irq_o | output | 1 | Data-ready interrupt request |

## Verification
The bench checks the ready flag one cycle before and one cycle after the settling count expires. A counter that is off by one shows ready a cycle early or a cycle late, and so do a counter that does not restart after deactivation and one that does not clear ready at once. It feeds a known bit pattern aligned to the sample period of three different range codes and compares every byte through a scoreboard, so a wrong divider, a wrong bit order or a miscounted byte length gives wrong bytes. It leaves one byte unread while a second completes, then reads the first back, which shows whether the held byte was overwritten. It also writes a new range code while the block is enabled and checks that the code stays unchanged, and it repeats the data read to confirm that the second read returns zero.

// File: rtl/rng_ctrl_pkg.sv
`timescale 1ns/100ps
package rng_ctrl_pkg;
  localparam int BUS_W  = 32;
  localparam int WORD_W = 8;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_DATA = 4'h4;
  localparam logic [3:0] OFS_RSVD = 4'h8;
  localparam logic [3:0] OFS_ACT  = 4'hC;

  localparam int CTL_EN    = 0;
  localparam int CTL_VALID = 1;
  localparam int CTL_CODE  = 2;
  localparam int CTL_IE    = 6;
  localparam int CTL_RDY   = 7;
  localparam int ACT_BIT   = 7;

  localparam logic [6:0] REV_ID = 7'h02;

  // upper bound of the clock range selected by a code, in MHz
  function automatic int unsigned range_top_mhz(input logic [3:0] code);
    case (code)
      4'd1:    return 80;
      4'd2:    return 60;
      4'd3:    return 50;
      4'd4:    return 40;
      4'd5:    return 30;
      4'd6:    return 25;
      4'd7:    return 20;
      4'd8:    return 15;
      4'd9:    return 12;
      4'd10:   return 9;
      4'd11:   return 7;
      4'd12:   return 6;
      4'd13:   return 5;
      default: return 100; // code 0 and reserved codes: slowest sampling
    endcase
  endfunction
endpackage

// File: rtl/rng_settle.sv
`timescale 1ns/100ps
module rng_settle #(
  parameter int SETTLE_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic ready_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!act_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // deactivation drops ready without waiting for the register
  assign ready_o = rdy_q & act_i;
endmodule

// File: rtl/rng_sampler.sv
`timescale 1ns/100ps
module rng_sampler #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] byte_o
);
  localparam int BC_W = $clog2(WORD_W);

  logic [DIV_W-1:0]  pc_q;
  logic [BC_W-1:0]   bc_q;
  logic [WORD_W-2:0] sh_q;
  logic              tick;

  assign tick = en_i && (pc_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      bc_q <= '0;
      sh_q <= '0;
    end else if (!en_i) begin
      pc_q <= '0;
      bc_q <= '0;
      sh_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
      sh_q <= {sh_q[WORD_W-3:0], bit_i};
      bc_q <= (bc_q == BC_W'(WORD_W - 1)) ? '0 : bc_q + BC_W'(1);
    end else begin
      pc_q <= pc_q + DIV_W'(1);
    end
  end

  assign done_o = tick && (bc_q == BC_W'(WORD_W - 1));
  assign byte_o = {sh_q, bit_i};
endmodule

// File: rtl/rng_ctrl.sv
`timescale 1ns/100ps
module rng_ctrl
  import rng_ctrl_pkg::*;
#(
  parameter int          SETTLE_CYC   = 20,
  parameter int unsigned DIV_UNIT_MHZ = 5,
  parameter int          ADDR_W       = 4,
  parameter int          DIV_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              entropy_i,
  output logic              irq_o
);
  logic              act_q, en_q, ie_q, valid_q;
  logic [3:0]        code_q;
  logic [WORD_W-1:0] data_q;
  logic              ready;
  logic              byte_done;
  logic [WORD_W-1:0] byte_new;
  logic [DIV_W-1:0]  div_val;

  logic wr_ctrl, wr_act, rd_data;
  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_act  = wr_i && (addr_i == ADDR_W'(OFS_ACT));
  assign rd_data = rd_i && (addr_i == ADDR_W'(OFS_DATA));

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[BUS_W-1:8], wdata_i[CTL_VALID]};

  always_comb begin
    int unsigned top;
    top     = range_top_mhz(code_q);
    div_val = DIV_W'((top + DIV_UNIT_MHZ - 1) / DIV_UNIT_MHZ);
    if (div_val == '0) div_val = DIV_W'(1);
  end

  rng_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act_q),
    .ready_o (ready)
  );

  rng_sampler #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .div_i  (div_val),
    .bit_i  (entropy_i),
    .done_o (byte_done),
    .byte_o (byte_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      code_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ie_q <= wdata_i[CTL_IE];
        en_q <= wdata_i[CTL_EN] & act_q & ready;
        if (!en_q) code_q <= wdata_i[CTL_CODE +: 4];
      end
      if (wr_act) begin
        act_q <= wdata_i[ACT_BIT];
        if (!wdata_i[ACT_BIT]) en_q <= 1'b0;
      end
      // a byte lands only in a free slot; a read this cycle frees it
      if (byte_done && (!valid_q || rd_data)) begin
        data_q  <= byte_new;
        valid_q <= 1'b1;
      end else if (rd_data) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CTRL): rdata_o[7:0] = {ready, ie_q, code_q, valid_q, en_q};
      ADDR_W'(OFS_DATA): if (valid_q) rdata_o[WORD_W-1:0] = data_q;
      ADDR_W'(OFS_ACT):  rdata_o[7:0] = {act_q, REV_ID};
      default:           rdata_o = '0;
    endcase
  end

  assign irq_o = valid_q & ie_q;
endmodule

// File: rtl/rng_ctrl_chk.sv
`timescale 1ns/100ps
module rng_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              act_q,
  input logic              ready,
  input logic              en_q,
  input logic [3:0]        code_q,
  input logic              valid_q,
  input logic [7:0]        data_q,
  input logic              byte_done
);
  logic rd_data, rd_rsvd;
  assign rd_data = rd_i && (addr_i == ADDR_W'(4'h4));
  assign rd_rsvd = rd_i && (addr_i == ADDR_W'(4'h8));

  p_en_needs_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (ready && act_q));

  p_ready_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !ready);

  p_code_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(code_q));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !byte_done) |=> !valid_q);

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !valid_q) |-> (rdata_o == 32'h0));

  p_no_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !rd_data) |=> (valid_q && $stable(data_q)));

  p_irq_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> valid_q);

  p_rsvd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsvd |-> (rdata_o == 32'h0));
endmodule

bind rng_ctrl rng_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .act_q     (act_q),
  .ready     (ready),
  .en_q      (en_q),
  .code_q    (code_q),
  .valid_q   (valid_q),
  .data_q    (data_q),
  .byte_done (byte_done)
);

// File: tb/rng_ctrl_tb_top.sv
`timescale 1ns/100ps
module rng_ctrl_tb_top;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        entropy = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  rng_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .entropy_i(entropy), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  // one byte, first bit = data bit 7, each held for a full sample period
  task automatic drive_byte(input logic [7:0] b, input int per, input bit stop_short);
    for (int k = 0; k < 8; k++) begin
      entropy = b[7-k];
      repeat ((k == 7 && stop_short) ? per - 1 : per) @(negedge clk);
    end
  endtask

  task automatic stream(input logic [7:0] pat[5], input int per);
    fork
      begin
        for (int i = 0; i < 5; i++) begin
          exp_q.push_back(pat[i]);
          drive_byte(pat[i], per, 1'b0);
        end
      end
      begin
        for (int i = 0; i < 5; i++) begin
          logic [31:0] v;
          logic [7:0]  e;
          while (!irq) @(negedge clk);
          bus_read(4'h4, v);
          e = exp_q.pop_front();
          check("R7 R8 stream byte", v, {24'h0, e});
        end
      end
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat_a[5];
    logic [7:0] pat_b[5];
    pat_a = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h7E};
    pat_b = '{8'h12, 8'hC3, 8'hF0, 8'h0F, 8'h99};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    read_chk("R1 ctrl", 4'h0, 32'h0);
    read_chk("R1 data", 4'h4, 32'h0);
    read_chk("R1 rsvd", 4'h8, 32'h0);
    read_chk("R1 act", 4'hC, 32'h2);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 version field read-only
    bus_write(4'hC, 32'hFFFF_FF7F);
    read_chk("R2 version", 4'hC, 32'h2);

    // R4 enable refused while inactive
    bus_write(4'h0, 32'h1);
    read_chk("R4 no act", 4'h0, 32'h0);

    // R3 settle timing, R4 enable refused while settling
    bus_write(4'hC, 32'h80);
    bus_write(4'h0, 32'h1);
    read_chk("R4 not ready", 4'h0, 32'h0);
    repeat (SETTLE - 3) @(negedge clk);
    read_chk("R3 before delay", 4'h0, 32'h0);
    read_chk("R3 after delay", 4'h0, 32'h80);

    // R7 first byte with code 7 (period 4), ie on
    bus_write(4'h0, 32'h5D);
    drive_byte(8'hA5, 4, 1'b1);
    check("R7 not yet valid", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R10 irq on valid", {31'h0, irq}, 32'h1);
    // R9 second byte completes while first unread
    drive_byte(8'h3C, 4, 1'b0);
    bus_write(4'h0, 32'h5C);
    read_chk("R9 still valid", 4'h0, 32'hDE);
    read_chk("R9 held byte", 4'h4, 32'hA5);
    read_chk("R8 valid cleared", 4'h0, 32'hDC);
    read_chk("R8 empty read", 4'h4, 32'h0);
    check("R10 irq off", {31'h0, irq}, 32'h0);

    // R6 code accepted while disabled; stream at period 1, then period 2
    bus_write(4'h0, 32'h75);
    read_chk("R6 code 13 taken", 4'h0, 32'hF5);
    bus_write(4'h0, 32'h74);
    bus_write(4'h0, 32'h75);
    stream(pat_a, 1);
    bus_write(4'h0, 32'h74);
    bus_write(4'h0, 32'h69);
    stream(pat_b, 2);

    // R6 code write ignored while enabled
    bus_write(4'h0, 32'h41);
    read_chk("R6 code kept", 4'h0, 32'hE9);

    // R10 valid without ie keeps irq low
    bus_write(4'h0, 32'h29);
    repeat (20) @(negedge clk);
    read_chk("R10 valid no ie", 4'h0, 32'hAB);
    check("R10 irq masked", {31'h0, irq}, 32'h0);

    // R5 deactivation and restart of the delay
    bus_write(4'hC, 32'h0);
    read_chk("R5 ready and en cleared", 4'h0, 32'h2A);
    read_chk("R5 act cleared", 4'hC, 32'h2);
    bus_write(4'hC, 32'h80);
    repeat (SETTLE - 1) @(negedge clk);
    read_chk("R5 restart not yet", 4'h0, 32'h2A);
    read_chk("R5 restart ready", 4'h0, 32'hAA);

    // R11 reserved offset
    bus_write(4'h8, 32'hFFFF_FFFF);
    read_chk("R11 rsvd", 4'h8, 32'h0);
    read_chk("R2 act readback", 4'hC, 32'h82);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule